// File: doc/BRIEF.md
# Three-Phase Carrier PWM Generator

This block drives three pulse-width-modulated phase outputs from a single shared carrier counter. The carrier is either a sawtooth that climbs from 1 to the period value and restarts at 1, or a triangle that climbs from 1 to the period value and falls back to 1. Each phase output is high while the carrier is below that phase's duty value. The three phases can share the U duty value or each use its own.

Period and duty values are first captured into shadow registers through a single write strobe. They reach the active registers only at carrier points chosen by the interrupt settings, so that a carrier period never mixes old and new values. An interrupt pulse is raised at those same points. It can fire every half period (triangle only), every period, every second period or every fourth period. A prescale option makes each carrier step four times longer. A run input stops the carrier and forces every output low.

Top module: `mpwm3_gen`

## Requirements
- R1: After reset, with run low, all three phase outputs and the interrupt output are low and the carrier is at 1.
- R2: In sawtooth mode (tri_mode=0) the carrier goes 1, 2, ... up to the period P and then back to 1. Each step lasts 1 clock with prescale4=0 and 4 clocks with prescale4=1.
- R3: In triangle mode (tri_mode=1) the carrier goes from 1 up to P and back down to 1, one unit per step. Each step lasts 2 clocks with prescale4=0 and 8 clocks with prescale4=1.
- R4: An active period value below 2 is treated as 2.
- R5: While running, a phase output is high when the carrier is less than its active duty value, or when that duty value is at least P. A duty value of 0 keeps the output low.
- R6: With duty_indep=0 all three phases use the U duty value. With duty_indep=1 phase U uses the U value, V the V value and W the W value.
- R7: A clock with shadow_we=1 captures prd_in and the three duty inputs into the shadow registers. The active registers copy the shadow registers on every clock while run is low. While running, they copy them only on a reload event.
- R8: An interrupt event is counted on the step that leaves a match point. In sawtooth mode the match point is carrier = P. In triangle mode it is carrier = 1 when irq_at_top=0 and carrier = P when irq_at_top=1. The irq output is high for exactly the one clock after that step.
- R9: irq_rate selects how many events make one interrupt: 2'b01 every event, 2'b10 every second event, 2'b11 every fourth event. The count starts at the first event after run rises, so the first interrupt is on event 1, 2 or 4.
- R10: With irq_rate=2'b00 in triangle mode, both carrier = 1 and carrier = P are events and every one interrupts. In sawtooth mode 2'b00 behaves as 2'b01.
- R11: A reload event is exactly an interrupt-generating step. The new duty values are visible at the outputs in the same clock in which irq is high.
- R12: While run is low, the carrier is held at 1, the step prescaler and the event count are cleared, and all phase outputs and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Carrier run enable |
| tri_mode | input | 1 | 0 sawtooth carrier, 1 triangle carrier |
| irq_rate | input | 2 | Interrupt decimation select |
| irq_at_top | input | 1 | Triangle match point: 0 at 1, 1 at period |
| duty_indep | input | 1 | 0 shared U duty, 1 per-phase duty |
| prescale4 | input | 1 | Stretch each carrier step by four |
| shadow_we | input | 1 | Capture period and duty inputs into shadow |
| prd_in | input | CW | Period value to capture |
| cmp_u_in | input | CW | U duty value to capture |
| cmp_v_in | input | CW | V duty value to capture |
| cmp_w_in | input | CW | W duty value to capture |
| pwm_u | output | 1 | Phase U output |
| pwm_v | output | 1 | Phase V output |
| pwm_w | output | 1 | Phase W output |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The hardest case to reach is a shadow write that arrives part way through a run. Its effect must show up only at the next decimated reload, and that reload can be many stretched triangle steps away. The stimulus sweeps every combination of carrier shape, prescale, interrupt rate, match point and duty mode, with both a normal and a too-small period. In each run it rewrites the duty values a third of the way in. A step-by-step arithmetic model of the carrier position and the event count predicts every output on every clock, so the exact clock of the reload is checked.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

  localparam int unsigned NPH = 3;

  typedef enum logic [1:0] {
    RATE_HALF = 2'b00,
    RATE_X1   = 2'b01,
    RATE_X2   = 2'b10,
    RATE_X4   = 2'b11
  } irq_rate_e;

endpackage

// File: rtl/mpwm_rst_sync.sv
module mpwm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/mpwm_prescale.sv
module mpwm_prescale #(
  parameter int unsigned SLOW_MUL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tri_mode,
  input  logic slow,
  output logic tick
);

  localparam int unsigned DIVW = $clog2(2 * SLOW_MUL);

  logic [DIVW-1:0] div_q, div_d;
  logic [DIVW:0]   base_len, step_len, last_idx;

  always_comb begin
    base_len = slow ? (DIVW+1)'(SLOW_MUL) : (DIVW+1)'(1);
    step_len = tri_mode ? (base_len << 1) : base_len;
    last_idx = step_len - (DIVW+1)'(1);
    tick     = run && (div_q == last_idx[DIVW-1:0]);
    if (!run || tick) div_d = '0;
    else              div_d = div_q + DIVW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2/R3: a stretched step never yields back-to-back ticks
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (slow || tri_mode)) |=> !tick)
    else $error("tick spacing violated");

endmodule

// File: rtl/mpwm_carrier.sv
module mpwm_carrier #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tri_mode,
  input  logic          tick,
  input  logic [CW-1:0] prd,
  output logic [CW-1:0] cnt,
  output logic          at_bot,
  output logic          at_top
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          down_q, down_d;

  always_comb begin
    cnt_d  = cnt_q;
    down_d = down_q;
    if (!run) begin
      cnt_d  = ONE;
      down_d = 1'b0;
    end else if (tick) begin
      if (!tri_mode) begin
        down_d = 1'b0;
        cnt_d  = (cnt_q >= prd) ? ONE : cnt_q + ONE;
      end else if (!down_q) begin
        if (cnt_q >= prd) begin
          cnt_d  = cnt_q - ONE;
          down_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_d  = cnt_q + ONE;
          down_d = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= ONE;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
    end
  end

  assign cnt    = cnt_q;
  assign at_bot = (cnt_q == ONE);
  assign at_top = (cnt_q == prd);

  // R12: idle carrier parks at 1
  a_r12_idle_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == ONE))
    else $error("carrier not parked");

  // R2: carrier moves only on a step tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt))
    else $error("carrier moved without tick");

  // R2: sawtooth restarts at 1 after the period value
  a_r2_saw_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !tri_mode && (cnt >= prd)) |=> (cnt == ONE))
    else $error("sawtooth wrap wrong");

  // R3: triangle moves one unit per step
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && tri_mode) |=>
      ((cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE)))
    else $error("triangle step size wrong");

  // R2/R3: carrier never reaches zero
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0)
    else $error("carrier at zero");

endmodule

// File: rtl/mpwm_irq_ctl.sv
module mpwm_irq_ctl
  import mpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      tick,
  input  logic      tri_mode,
  input  irq_rate_e rate,
  input  logic      top_sel,
  input  logic      at_bot,
  input  logic      at_top,
  output logic      fire,
  output logic      irq
);

  logic [1:0] dec_q, dec_d;
  logic [1:0] mask;
  logic       ev_half, ev_base, ev;
  logic       irq_q, irq_d;

  always_comb begin
    ev_half = tri_mode ? (at_bot || at_top) : at_top;
    ev_base = tri_mode ? (top_sel ? at_top : at_bot) : at_top;
    ev      = tick && ((rate == RATE_HALF) ? ev_half : ev_base);
    unique case (rate)
      RATE_X2: mask = 2'b01;
      RATE_X4: mask = 2'b11;
      default: mask = 2'b00;
    endcase
    fire  = ev && ((dec_q & mask) == mask);
    if (!run)    dec_d = 2'b00;
    else if (ev) dec_d = dec_q + 2'b01;
    else         dec_d = dec_q;
    irq_d = run && fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= 2'b00;
      irq_q <= 1'b0;
    end else begin
      dec_q <= dec_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R8: interrupt is a single-clock pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq)
    else $error("irq longer than one clock");

  // R12: no interrupt after an idle clock
  a_r12_no_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq)
    else $error("irq while idle");

  // R8: an interrupt always follows a step tick
  a_r8_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !irq)
    else $error("irq without step");

endmodule

// File: rtl/mpwm_shadow.sv
module mpwm_shadow
  import mpwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic                    fire,
  input  logic                    we,
  input  logic [CW-1:0]           prd_in,
  input  logic [NPH-1:0][CW-1:0]  cmp_in,
  output logic [CW-1:0]           act_prd,
  output logic [NPH-1:0][CW-1:0]  act_cmp
);

  localparam logic [CW-1:0] MIN_PRD = CW'(2);

  logic [CW-1:0]          sh_prd_q, sh_prd_d;
  logic [NPH-1:0][CW-1:0] sh_cmp_q, sh_cmp_d;
  logic [CW-1:0]          act_prd_q, act_prd_d;
  logic [NPH-1:0][CW-1:0] act_cmp_q, act_cmp_d;
  logic                   load;

  always_comb begin
    load      = !run || fire;
    sh_prd_d  = we ? prd_in : sh_prd_q;
    act_prd_d = act_prd_q;
    if (load) act_prd_d = (sh_prd_q < MIN_PRD) ? MIN_PRD : sh_prd_q;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_cmp
    always_comb begin
      sh_cmp_d[i]  = we ? cmp_in[i] : sh_cmp_q[i];
      act_cmp_d[i] = load ? sh_cmp_q[i] : act_cmp_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prd_q  <= '0;
      sh_cmp_q  <= '0;
      act_prd_q <= MIN_PRD;
      act_cmp_q <= '0;
    end else begin
      sh_prd_q  <= sh_prd_d;
      sh_cmp_q  <= sh_cmp_d;
      act_prd_q <= act_prd_d;
      act_cmp_q <= act_cmp_d;
    end
  end

  assign act_prd = act_prd_q;
  assign act_cmp = act_cmp_q;

  // R7: active values are frozen between reload events while running
  a_r7_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fire) |=> ($stable(act_prd) && $stable(act_cmp)))
    else $error("active registers changed outside reload");

  // R4: active period never below 2
  a_r4_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    act_prd >= MIN_PRD)
    else $error("active period below minimum");

endmodule

// File: rtl/mpwm_phase.sv
module mpwm_phase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] prd,
  input  logic [CW-1:0] cmp,
  output logic          out
);

  logic full_on;
  logic below;

  always_comb begin
    full_on = (cmp >= prd);
    below   = (cnt < cmp);
    out     = run && (full_on || below);
  end

  // R5: zero duty never drives the phase high
  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> !out)
    else $error("zero duty produced high output");

  // R12: stopped carrier keeps the phase low
  a_r12_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !out)
    else $error("phase high while idle");

endmodule

// File: rtl/mpwm3_gen.sv
module mpwm3_gen
  import mpwm_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned SLOW_MUL = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tri_mode,
  input  logic [1:0]    irq_rate,
  input  logic          irq_at_top,
  input  logic          duty_indep,
  input  logic          prescale4,
  input  logic          shadow_we,
  input  logic [CW-1:0] prd_in,
  input  logic [CW-1:0] cmp_u_in,
  input  logic [CW-1:0] cmp_v_in,
  input  logic [CW-1:0] cmp_w_in,
  output logic          pwm_u,
  output logic          pwm_v,
  output logic          pwm_w,
  output logic          irq
);

  logic                   rst_sync_n;
  logic                   tick;
  logic [CW-1:0]          cnt;
  logic                   at_bot, at_top;
  logic                   fire;
  logic [CW-1:0]          act_prd;
  logic [NPH-1:0][CW-1:0] act_cmp;
  logic [NPH-1:0][CW-1:0] cmp_in;
  logic [NPH-1:0][CW-1:0] sel_cmp;
  logic [NPH-1:0]         pwm;

  assign cmp_in = {cmp_w_in, cmp_v_in, cmp_u_in};

  mpwm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mpwm_prescale #(.SLOW_MUL(SLOW_MUL)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .tri_mode (tri_mode),
    .slow     (prescale4),
    .tick     (tick)
  );

  mpwm_carrier #(.CW(CW)) u_car (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .tri_mode (tri_mode),
    .tick     (tick),
    .prd      (act_prd),
    .cnt      (cnt),
    .at_bot   (at_bot),
    .at_top   (at_top)
  );

  mpwm_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .tick     (tick),
    .tri_mode (tri_mode),
    .rate     (irq_rate_e'(irq_rate)),
    .top_sel  (irq_at_top),
    .at_bot   (at_bot),
    .at_top   (at_top),
    .fire     (fire),
    .irq      (irq)
  );

  mpwm_shadow #(.CW(CW)) u_sh (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (run),
    .fire    (fire),
    .we      (shadow_we),
    .prd_in  (prd_in),
    .cmp_in  (cmp_in),
    .act_prd (act_prd),
    .act_cmp (act_cmp)
  );

  for (genvar i = 0; i < NPH; i++) begin : g_ph
    assign sel_cmp[i] = duty_indep ? act_cmp[i] : act_cmp[0];
    mpwm_phase #(.CW(CW)) u_ph (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .run   (run),
      .cnt   (cnt),
      .prd   (act_prd),
      .cmp   (sel_cmp[i]),
      .out   (pwm[i])
    );
  end

  assign pwm_u = pwm[0];
  assign pwm_v = pwm[1];
  assign pwm_w = pwm[2];

  // R6: in shared mode all phases agree
  a_r6_shared_equal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !duty_indep |-> ((pwm_u == pwm_v) && (pwm_v == pwm_w)))
    else $error("shared duty mode phases differ");

endmodule

// File: tb/mpwm3_gen_test.sv
module mpwm3_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk;
  logic          rst_n;
  logic          run;
  logic          tri_mode;
  logic [1:0]    irq_rate;
  logic          irq_at_top;
  logic          duty_indep;
  logic          prescale4;
  logic          shadow_we;
  logic [CW-1:0] prd_in, cmp_u_in, cmp_v_in, cmp_w_in;
  logic          pwm_u, pwm_v, pwm_w, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int m_s, m_div, m_evn, m_pe;
  bit m_irq, m_run;
  int m_sh[3];
  int m_act[3];

  mpwm3_gen uut (
    .clk(clk), .rst_n(rst_n), .run(run), .tri_mode(tri_mode),
    .irq_rate(irq_rate), .irq_at_top(irq_at_top), .duty_indep(duty_indep),
    .prescale4(prescale4), .shadow_we(shadow_we), .prd_in(prd_in),
    .cmp_u_in(cmp_u_in), .cmp_v_in(cmp_v_in), .cmp_w_in(cmp_w_in),
    .pwm_u(pwm_u), .pwm_v(pwm_v), .pwm_w(pwm_w), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  function automatic int val_of(input int s);
    int pos;
    if (!tri_mode) return 1 + (s % m_pe);
    pos = s % (2 * (m_pe - 1));
    return (pos <= m_pe - 1) ? 1 + pos : 2 * m_pe - 1 - pos;
  endfunction

  function automatic bit exp_out(input int c);
    if (!m_run) return 1'b0;
    return (c >= m_pe) || (val_of(m_s) < c);
  endfunction

  task automatic model_edge();
    int len, n, v;
    bit tick, ev, fire;
    len = (prescale4 ? 4 : 1) * (tri_mode ? 2 : 1);
    n = (irq_rate == 2'b10) ? 2 : (irq_rate == 2'b11) ? 4 : 1;
    fire = 1'b0;
    m_run = run;
    if (!run) begin
      m_div = 0; m_s = 0; m_evn = 0;
      for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
    end else begin
      tick = (m_div == len - 1);
      m_div = tick ? 0 : m_div + 1;
      if (tick) begin
        v = val_of(m_s);
        if (tri_mode && irq_rate == 2'b00) ev = (v == 1) || (v == m_pe);
        else if (tri_mode) ev = irq_at_top ? (v == m_pe) : (v == 1);
        else ev = (v == m_pe);
        if (ev) begin
          m_evn++;
          fire = (m_evn % n) == 0;
        end
        m_s++;
      end
      if (fire) for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
    end
    m_irq = fire;
    if (shadow_we) begin
      m_sh[0] = cmp_u_in; m_sh[1] = cmp_v_in; m_sh[2] = cmp_w_in;
    end
  endtask

  task automatic step_check(input string tag);
    int cu, cv, cw;
    string ptag, itag;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cu = m_act[0];
    cv = duty_indep ? m_act[1] : m_act[0];
    cw = duty_indep ? m_act[2] : m_act[0];
    ptag = $sformatf("%s %s R5 R6 R7%s", tag, tri_mode ? "R3" : "R2",
                     (prd_in < 2) ? " R4" : "");
    itag = $sformatf("%s R8 %s", tag,
                     (irq_rate == 2'b00) ? "R10" : "R9");
    check(pwm_u, exp_out(cu), {ptag, " pwm_u"});
    check(pwm_v, exp_out(cv), {ptag, " pwm_v"});
    check(pwm_w, exp_out(cw), {ptag, " pwm_w"});
    check(irq, m_irq, itag);
  endtask

  task automatic run_config(input bit tr, input bit sl, input bit [1:0] rt,
                            input bit tp, input bit ind, input int pin);
    int len, ncyc;
    tri_mode = tr; prescale4 = sl; irq_rate = rt; irq_at_top = tp;
    duty_indep = ind; run = 1'b0;
    prd_in = CW'(pin);
    cmp_u_in = 16'd2; cmp_v_in = 16'd5; cmp_w_in = 16'd0;
    m_pe = (pin < 2) ? 2 : pin;
    shadow_we = 1'b1;
    step_check("R7 R12");
    shadow_we = 1'b0;
    step_check("R7 R12");
    len = (sl ? 4 : 1) * (tr ? 2 : 1);
    ncyc = 20 * len * m_pe + 20;
    run = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      if (k == ncyc / 3) begin
        cmp_u_in = 16'd4; cmp_v_in = 16'd1; cmp_w_in = 16'd3;
        shadow_we = 1'b1;
      end else begin
        shadow_we = 1'b0;
      end
      step_check((k > ncyc / 3) ? "R11" : "run");
    end
    run = 1'b0;
    step_check("R12");
    step_check("R12");
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; tri_mode = 1'b0; irq_rate = 2'b00;
    irq_at_top = 1'b0; duty_indep = 1'b0; prescale4 = 1'b0;
    shadow_we = 1'b0; prd_in = '0; cmp_u_in = '0; cmp_v_in = '0; cmp_w_in = '0;
    for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    m_s = 0; m_div = 0; m_evn = 0; m_irq = 0; m_run = 0; m_pe = 2;
    repeat (4) @(negedge clk);
    // R1: outputs low during and after reset
    check(pwm_u | pwm_v | pwm_w, 1'b0, "R1 phases in reset");
    check(irq, 1'b0, "R1 irq in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(pwm_u | pwm_v | pwm_w, 1'b0, "R1 phases after reset");
    check(irq, 1'b0, "R1 irq after reset");
    for (int pi = 0; pi < 2; pi++)
      for (int tr = 0; tr < 2; tr++)
        for (int sl = 0; sl < 2; sl++)
          for (int rt = 0; rt < 4; rt++)
            for (int tp = 0; tp < 2; tp++)
              for (int ind = 0; ind < 2; ind++)
                run_config(tr[0], sl[0], rt[1:0], tp[0], ind[0],
                           (pi == 0) ? 5 : 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule